// File: doc/BRIEF.md
# Event-Select Performance Counter Bank

This block is a bank of eight 64-bit event counters for one slice of a last-level cache. The cache logic presents a vector of single-cycle event strobes, indexed by event code, plus two 6-bit occupancy levels: one for the fill buffer and one for request tracking. Each counter has its own 8-bit selector. The selector picks which strobe or occupancy level the counter adds up.

There is no separate run bit. A counter runs while its selector holds a defined nonzero code. Code zero freezes it, and so does any code above the defined range. Software reaches both the counters and the selectors through a simple register port. A read is answered on the following cycle. The usual sequence is to clear a counter, write a selector code to start it, later write zero to the selector to stop it, and then read the count back.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset, every counter and every selector reads back as zero, and the read data output is zero.
- R2: Counter n (n = 0..7) is at offset 0x800 + 8·n and its selector is at 0x900 + 8·n. A read request (valid high, write low) in one cycle puts the addressed value on the read data output after the next rising edge. In every other cycle that output is driven to zero.
- R3: A selector write stores only bits 7:0 of the write data. A selector readback returns that byte in bits 7:0, with bits 63:8 zero.
- R4: With selector value 0x00 the counter holds its value, whatever the strobes and occupancy inputs do.
- R5: With a selector code from 0x01 to 0x22, the counter adds 1 on each rising edge at which strobe bit [code] is high. It ignores every other strobe bit.
- R6: Code 0x23 adds the fill-buffer occupancy input on each edge. Code 0x24 adds the request-tracking occupancy input on each edge.
- R7: Selector codes 0x25 to 0xFF leave the counter halted, exactly as code 0x00 does.
- R8: A counter write replaces the count with the written value. If the same edge would also add an increment, the written value wins.
- R9: Counters wrap modulo 2^64 and raise no flag.
- R10: Reads of unmapped or misaligned offsets return zero. Writes to such offsets change no counter and no selector.
- R11: Each counter follows only its own selector, so counters with different codes count independently in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_strobe | input | 37 | Per-cycle event strobes; bit k is event code k (bit 0 unused) |
| ifb_occ | input | 6 | Fill-buffer occupancy level, used by code 0x23 |
| req_occ | input | 6 | Request-tracking occupancy level, used by code 0x24 |
| reg_valid | input | 1 | Register access request this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the cycle after a read request |

## Verification
A wrong selector byte shows up at the ports as a counter that misses its strobes, or one that follows a neighbouring code. The counter readback exposes this within one read. A wrong decode shows up as a misplaced or corrupted register: a write lands in one slot and appears in another, which the next readback of either slot reveals. Each stimulus window in the bench runs a known number of edges. A single missed or extra increment therefore changes the readback by exactly one step, or by one occupancy value, and the bench's exact-value comparison catches it.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  localparam int NUM_CTR  = 8;
  localparam int CTR_W    = 64;
  localparam int SEL_W    = 8;
  localparam int OCC_W    = 6;
  localparam int ADDR_W   = 12;
  localparam int CODE_IFB = 'h23;
  localparam int CODE_REQ = 'h24;
  localparam int CODE_MAX = 'h24;
  localparam int NUM_EVT  = CODE_MAX + 1;
  localparam int CTR_BASE = 'h800;
  localparam int SEL_BASE = 'h900;
  localparam int STRIDE_B = 3;

  // a selector code starts the counter only when it is defined and nonzero
  function automatic logic code_live(input logic [SEL_W-1:0] code);
    return (code != '0) && (int'(code) <= CODE_MAX);
  endfunction

  // next count: modulo add of the step
  function automatic logic [CTR_W-1:0] count_step(input logic [CTR_W-1:0] cur,
                                                   input logic [OCC_W-1:0] step);
    return cur + CTR_W'(step);
  endfunction
endpackage

// File: rtl/ecb_regdec.sv
module ecb_regdec
  import ecb_pkg::*;
#(
  parameter int N_CTR = NUM_CTR,
  parameter int AW    = ADDR_W,
  localparam int IDX_W = (N_CTR > 1) ? $clog2(N_CTR) : 1
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [AW-1:0]     acc_addr,
  output logic              hit_ctr,
  output logic              hit_sel,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [N_CTR-1:0]  wr_ctr_vec,
  output logic [N_CTR-1:0]  wr_sel_vec
);
  localparam int SPAN = N_CTR << STRIDE_B;

  logic aligned;
  logic in_ctr, in_sel;

  always_comb begin
    aligned = (acc_addr[STRIDE_B-1:0] == '0);
    in_ctr  = (int'(acc_addr) >= CTR_BASE) && (int'(acc_addr) < CTR_BASE + SPAN);
    in_sel  = (int'(acc_addr) >= SEL_BASE) && (int'(acc_addr) < SEL_BASE + SPAN);
    hit_ctr = acc_valid && aligned && in_ctr;
    hit_sel = acc_valid && aligned && in_sel;
    hit_idx = acc_addr[STRIDE_B +: IDX_W];
  end

  generate
    for (genvar g = 0; g < N_CTR; g++) begin : g_wr
      assign wr_ctr_vec[g] = hit_ctr && acc_write && (int'(hit_idx) == g);
      assign wr_sel_vec[g] = hit_sel && acc_write && (int'(hit_idx) == g);
    end
  endgenerate
endmodule

// File: rtl/ecb_evmux.sv
module ecb_evmux
  import ecb_pkg::*;
#(
  parameter int N_EVT = NUM_EVT
) (
  input  logic [SEL_W-1:0] code,
  input  logic [N_EVT-1:0] strobes,
  input  logic [OCC_W-1:0] occ_ifb,
  input  logic [OCC_W-1:0] occ_req,
  output logic             live,
  output logic [OCC_W-1:0] step
);
  always_comb begin
    live = code_live(code);
    step = '0;
    if (live) begin
      if (int'(code) == CODE_IFB)      step = occ_ifb;
      else if (int'(code) == CODE_REQ) step = occ_req;
      else                             step = OCC_W'(strobes[code]);
    end
  end
endmodule

// File: rtl/ecb_counter.sv
module ecb_counter
  import ecb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_wr,
  input  logic             sel_wr,
  input  logic [CTR_W-1:0] wdata,
  input  logic [OCC_W-1:0] step,
  output logic [CTR_W-1:0] cnt,
  output logic [SEL_W-1:0] sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sel <= '0;
    end else begin
      if (cnt_wr) cnt <= wdata;
      else        cnt <= count_step(cnt, step);
      if (sel_wr) sel <= wdata[SEL_W-1:0];
    end
  end

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(wdata)); // R8
  AST_SEL_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> sel == $past(wdata[SEL_W-1:0])); // R3
  AST_SEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> $stable(sel)); // R10
endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank
  import ecb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_strobe,
  input  logic [OCC_W-1:0]   ifb_occ,
  input  logic [OCC_W-1:0]   req_occ,
  input  logic               reg_valid,
  input  logic               reg_write,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [CTR_W-1:0]   reg_wdata,
  output logic [CTR_W-1:0]   reg_rdata
);
  localparam int IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;

  logic               hit_ctr, hit_sel;
  logic [IDX_W-1:0]   hit_idx;
  logic [NUM_CTR-1:0] wr_ctr_vec, wr_sel_vec;
  logic [CTR_W-1:0]   cnt_arr  [NUM_CTR];
  logic [SEL_W-1:0]   sel_arr  [NUM_CTR];
  logic [OCC_W-1:0]   step_arr [NUM_CTR];
  logic [NUM_CTR-1:0] live_vec;
  logic [CTR_W-1:0]   rd_next;
  logic               rd_req;

  ecb_regdec #(.N_CTR(NUM_CTR), .AW(ADDR_W)) dec_i (
    .acc_valid (reg_valid),
    .acc_write (reg_write),
    .acc_addr  (reg_addr),
    .hit_ctr   (hit_ctr),
    .hit_sel   (hit_sel),
    .hit_idx   (hit_idx),
    .wr_ctr_vec(wr_ctr_vec),
    .wr_sel_vec(wr_sel_vec)
  );

  generate
    for (genvar g = 0; g < NUM_CTR; g++) begin : g_slot
      ecb_evmux #(.N_EVT(NUM_EVT)) mux_i (
        .code   (sel_arr[g]),
        .strobes(evt_strobe),
        .occ_ifb(ifb_occ),
        .occ_req(req_occ),
        .live   (live_vec[g]),
        .step   (step_arr[g])
      );
      ecb_counter ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_wr(wr_ctr_vec[g]),
        .sel_wr(wr_sel_vec[g]),
        .wdata (reg_wdata),
        .step  (step_arr[g]),
        .cnt   (cnt_arr[g]),
        .sel   (sel_arr[g])
      );

      AST_ZERO_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_arr[g] == '0 && !wr_ctr_vec[g]) |=> $stable(cnt_arr[g])); // R4
      AST_RESERVED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel_arr[g]) > CODE_MAX && !wr_ctr_vec[g]) |=> $stable(cnt_arr[g])); // R7
      AST_IDLE_STEP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !live_vec[g] |-> step_arr[g] == '0); // R7
    end
  endgenerate

  always_comb begin
    rd_req  = reg_valid && !reg_write;
    rd_next = '0;
    if (rd_req && hit_ctr)      rd_next = cnt_arr[hit_idx];
    else if (rd_req && hit_sel) rd_next = CTR_W'(sel_arr[hit_idx]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_next;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_write && !hit_ctr && !hit_sel) |=> reg_rdata == '0); // R10
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_valid && !reg_write) |=> reg_rdata == '0); // R2
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_ctr, hit_sel})); // R2
endmodule

// File: tb/evt_counter_bank_tb.sv
`timescale 1ns/1ps
module evt_counter_bank_tb_top;
  import ecb_pkg::*;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_EVT-1:0] evt_strobe = '0;
  logic [OCC_W-1:0]   ifb_occ = '0;
  logic [OCC_W-1:0]   req_occ = '0;
  logic               reg_valid = 1'b0;
  logic               reg_write = 1'b0;
  logic [ADDR_W-1:0]  reg_addr = '0;
  logic [CTR_W-1:0]   reg_wdata = '0;
  logic [CTR_W-1:0]   reg_rdata;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  evt_counter_bank dut_i (
    .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe), .ifb_occ(ifb_occ),
    .req_occ(req_occ), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  typedef struct packed {
    logic [2:0]  idx;
    logic [7:0]  code;
    logic [5:0]  occ;
    logic        skip_own;
    logic [7:0]  cycles;
    logic [15:0] expect_v;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'h01, 6'd0,  1'b0, 8'd5, 16'd5},   // R5
    '{3'd3, 8'h22, 6'd0,  1'b0, 8'd7, 16'd7},   // R5
    '{3'd5, 8'h23, 6'd10, 1'b0, 8'd4, 16'd40},  // R6 fill buffer
    '{3'd6, 8'h24, 6'd5,  1'b0, 8'd3, 16'd18},  // R6 request level = occ+1
    '{3'd7, 8'h25, 6'd9,  1'b0, 8'd6, 16'd0},   // R7
    '{3'd2, 8'hFF, 6'd9,  1'b0, 8'd6, 16'd0},   // R7
    '{3'd1, 8'h10, 6'd0,  1'b1, 8'd6, 16'd0},   // R5 other strobes ignored
    '{3'd4, 8'h00, 6'd7,  1'b0, 8'd4, 16'd0}    // R4
  };

  function automatic logic [ADDR_W-1:0] ctr_addr(input int n);
    return ADDR_W'('h800 + 8 * n);
  endfunction
  function automatic logic [ADDR_W-1:0] sel_addr(input int n);
    return ADDR_W'('h900 + 8 * n);
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%016h expected 0x%016h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_valid = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [NUM_EVT-1:0] s, input logic [5:0] o, input int n);
    @(negedge clk);
    evt_strobe = s; ifb_occ = o; req_occ = o + 6'd1;
    repeat (n) @(negedge clk);
    evt_strobe = '0; ifb_occ = '0; req_occ = '0;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [63:0] v;
    logic [NUM_EVT-1:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 rdata after reset", reg_rdata, 64'd0);
    rd(ctr_addr(3), v); check("R1 counter reset", v, 64'd0);
    rd(sel_addr(6), v); check("R1 selector reset", v, 64'd0);

    for (int i = 0; i < NV; i++) begin
      wr(ctr_addr(VECS[i].idx), 64'd0);
      wr(sel_addr(VECS[i].idx), {56'd0, VECS[i].code});
      s = '1;
      if (VECS[i].skip_own) s[VECS[i].code] = 1'b0;
      pulse(s, VECS[i].occ, int'(VECS[i].cycles));
      rd(ctr_addr(VECS[i].idx), v);
      check($sformatf("R5/R6/R7/R4 vector %0d", i), v, 64'(VECS[i].expect_v));
    end

    // R2 selector placement at the last slot
    wr(sel_addr(7), 64'h0000_0000_0000_0013);
    rd(sel_addr(7), v); check("R2 selector slot 7", v, 64'h13);
    // R3 upper selector bits dropped
    wr(sel_addr(1), 64'hDEAD_BEEF_FFFF_FF05);
    rd(sel_addr(1), v); check("R3 selector low byte", v, 64'h05);

    // R8 write beats a same-cycle increment
    wr(sel_addr(0), 64'h01);
    @(negedge clk);
    evt_strobe = '0; evt_strobe[1] = 1'b1;
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = ctr_addr(0); reg_wdata = 64'd100;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0; evt_strobe = '0;
    rd(ctr_addr(0), v); check("R8 write wins", v, 64'd100);

    // R4 stop with code zero then hold
    wr(sel_addr(0), 64'h00);
    pulse('1, 6'd3, 5);
    rd(ctr_addr(0), v); check("R4 hold after stop", v, 64'd100);

    // R9 wrap
    wr(ctr_addr(5), 64'hFFFF_FFFF_FFFF_FFFE);
    wr(sel_addr(5), 64'h23);
    pulse('0, 6'd3, 1);
    rd(ctr_addr(5), v); check("R9 wrap", v, 64'd1);

    // R10 unmapped and misaligned
    rd(12'h804, v); check("R10 misaligned read", v, 64'd0);
    rd(12'hA00, v); check("R10 unmapped read", v, 64'd0);
    wr(12'h840, 64'd55);
    wr(12'h904, 64'h7);
    rd(ctr_addr(0), v); check("R10 counter untouched", v, 64'd100);
    rd(sel_addr(0), v); check("R10 selector untouched", v, 64'd0);

    // R11 independent counters
    wr(ctr_addr(2), 64'd0); wr(ctr_addr(3), 64'd0);
    wr(sel_addr(2), 64'h02); wr(sel_addr(3), 64'h03);
    s = '0; s[2] = 1'b1;
    pulse(s, 6'd0, 4);
    wr(sel_addr(2), 64'h00); wr(sel_addr(3), 64'h00);
    rd(ctr_addr(2), v); check("R11 selected counter", v, 64'd4);
    rd(ctr_addr(3), v); check("R11 other counter", v, 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule